// File: doc/BRIEF.md
# I/O Pad Function and Wakeup Control Register

This block holds the control word for a single I/O pad and serves it through a plain 32-bit write strobe and a combinational read port. The word selects the pad's alternate function, its output/input arrangement, its low-power behaviour, its pull resistor, its drive setting and a wakeup detection mode. Every stored field is presented on decoded output pins for the pad cell and the pin multiplexer.

A write does not update the whole word. Three qualifier bits in the written data decide which field groups take the new value. Bit 31 enables the function group. Bit 30 enables the pull and drive group. Bit 22 enables the wakeup mode. Software can therefore retune the pull resistor without touching the function selection, or rearm the wakeup logic on its own.

The wakeup detector passes the pad input through a synchronizer. It then watches the synchronized level, or its edges, according to the stored mode, and raises a sticky flag when the condition is met. An interrupt pulse marks the cycle in which the flag rises. A wakeup-field write carrying the resample code clears the flag and leaves the stored mode as it was.

Top module: `pad_ctl_reg`

## Requirements
- R1: After reset every stored field is zero: function 0, I/O config 00, low-power 00, wakeup mode 000 (off), pull 00 (bus-keeper), drive 000. `rd_data` reads 0 and `wake_flag` and `wake_irq` are low.
- R2: A write updates the function (bits 29:27), I/O config (bits 26:25) and low-power mode (bits 24:23) only when bit 31 of the written data is 1. Otherwise those fields keep their values.
- R3: A write updates the pull field (bits 6:5) and the drive field (bits 2:0) only when bit 30 of the written data is 1.
- R4: A write updates the wakeup mode (bits 21:19) only when bit 22 of the written data is 1. This qualifier has no effect on the other fields.
- R5: The wakeup codes are 000 off, 001 resample, 100 low, 101 fall, 110 rise and 111 high. A qualified write of 001 keeps the stored mode and clears the flag. A qualified write of 010 or 011 changes nothing.
- R6: `rd_data` returns the stored fields at their write positions. Bits 31, 30 and 22 and all reserved bits (18:7 and 4:3) read 0.
- R7: The pad input goes through a two-flop synchronizer. In mode low or high, the flag rises on the third rising clock edge after the pad settles at the matching level.
- R8: In mode rise or fall, the flag is set only by a transition of the synchronized input in the matching direction, and it rises on the third edge after the pad changes.
- R9: In mode off, or with a stored mode of 001, the flag is never set.
- R10: The flag stays set until a resample write or reset. If a detection and a resample write fall on the same edge, the flag stays set.
- R11: `wake_irq` is high for exactly the one cycle in which `wake_flag` goes from 0 to 1.
- R12: `mux_sel`, `io_cfg`, `lp_cfg`, `pull_sel` and `drive_sel` always equal the stored fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; data captured on the rising edge |
| wr_data | input | 32 | Write data, including the three qualifier bits |
| rd_data | output | 32 | Readback of stored fields |
| pad_in | input | 1 | Asynchronous pad input level |
| mux_sel | output | 3 | Alternate function select |
| io_cfg | output | 2 | Output/input configuration |
| lp_cfg | output | 2 | Low-power configuration |
| pull_sel | output | 2 | Pull resistor select |
| drive_sel | output | 3 | Drive setting, 111 = high speed |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | One-cycle pulse when the flag rises |

## Verification
The assertions assume that `wr_en` and `wr_data` are synchronous to `clk` and stable around its rising edge. They also assume that `pad_in` is held for at least one clock, so the synchronizer sees every level the bench drives. The bench changes all inputs on the falling edge and holds each pad level for several cycles before it looks at the flag. Within that window, the only timing that matters is the fixed three-edge latency through the synchronizer and the flag register.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;
  localparam int REG_W        = 32;
  localparam int MUX_UPD_BIT  = 31;
  localparam int PAD_UPD_BIT  = 30;
  localparam int WAKE_UPD_BIT = 22;
  localparam int MUX_LSB  = 27;
  localparam int MUX_W    = 3;
  localparam int IOC_LSB  = 25;
  localparam int IOC_W    = 2;
  localparam int LPM_LSB  = 23;
  localparam int LPM_W    = 2;
  localparam int WAKE_LSB = 19;
  localparam int WAKE_W   = 3;
  localparam int PULL_LSB = 5;
  localparam int PULL_W   = 2;
  localparam int DRV_LSB  = 0;
  localparam int DRV_W    = 3;

  typedef enum logic [WAKE_W-1:0] {
    WK_OFF      = 3'b000,
    WK_RESAMPLE = 3'b001,
    WK_LOW      = 3'b100,
    WK_FALL     = 3'b101,
    WK_RISE     = 3'b110,
    WK_HIGH     = 3'b111
  } wake_mode_e;

  typedef struct packed {
    logic [MUX_W-1:0]  mux;
    logic [IOC_W-1:0]  ioc;
    logic [LPM_W-1:0]  lpm;
    logic [WAKE_W-1:0] wake;
    logic [PULL_W-1:0] pull;
    logic [DRV_W-1:0]  drv;
  } pad_fields_t;

  // A wakeup code is stored only if it is off or one of the detecting modes.
  function automatic logic wake_code_storable(input logic [WAKE_W-1:0] c);
    return (c == WK_OFF) || c[WAKE_W-1];
  endfunction

  // Detection condition for a mode, from the current and previous synchronized levels.
  function automatic logic wake_condition(input logic [WAKE_W-1:0] m,
                                          input logic cur, input logic prev);
    case (m)
      WK_LOW:  return ~cur;
      WK_HIGH: return cur;
      WK_FALL: return prev & ~cur;
      WK_RISE: return ~prev & cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_readback(input pad_fields_t f);
    logic [REG_W-1:0] r;
    r = '0;
    r[MUX_LSB  +: MUX_W]  = f.mux;
    r[IOC_LSB  +: IOC_W]  = f.ioc;
    r[LPM_LSB  +: LPM_W]  = f.lpm;
    r[WAKE_LSB +: WAKE_W] = f.wake;
    r[PULL_LSB +: PULL_W] = f.pull;
    r[DRV_LSB  +: DRV_W]  = f.drv;
    return r;
  endfunction
endpackage

// File: rtl/pad_ctl_fields.sv
module pad_ctl_fields
  import pad_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output pad_fields_t      fields,
  output logic             resample_clr
);
  logic        mux_we, pad_we, wake_qual, wake_we;
  logic [WAKE_W-1:0] wake_code;

  assign mux_we       = wr_en & wr_data[MUX_UPD_BIT];
  assign pad_we       = wr_en & wr_data[PAD_UPD_BIT];
  assign wake_qual    = wr_en & wr_data[WAKE_UPD_BIT];
  assign wake_code    = wr_data[WAKE_LSB +: WAKE_W];
  assign wake_we      = wake_qual & wake_code_storable(wake_code);
  assign resample_clr = wake_qual & (wake_code == WK_RESAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else begin
      if (mux_we) begin
        fields.mux <= wr_data[MUX_LSB +: MUX_W];
        fields.ioc <= wr_data[IOC_LSB +: IOC_W];
        fields.lpm <= wr_data[LPM_LSB +: LPM_W];
      end
      if (pad_we) begin
        fields.pull <= wr_data[PULL_LSB +: PULL_W];
        fields.drv  <= wr_data[DRV_LSB +: DRV_W];
      end
      if (wake_we) fields.wake <= wake_code;
    end
  end
endmodule

// File: rtl/pad_wake_det.sv
module pad_wake_det
  import pad_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  input  logic [WAKE_W-1:0] mode,
  input  logic              clr,
  output logic              hit,
  output logic              flag,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;
  logic                   cur;

  assign cur = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain[0] <= pad_in;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= cur;
    end
  end

  assign hit = wake_condition(mode, cur, prev_q);

  // Detection wins over a same-cycle clear so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= hit & ~flag;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pad_ctl_reg.sv
module pad_ctl_reg
  import pad_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        pad_in,
  output logic [2:0]  mux_sel,
  output logic [1:0]  io_cfg,
  output logic [1:0]  lp_cfg,
  output logic [1:0]  pull_sel,
  output logic [2:0]  drive_sel,
  output logic        wake_flag,
  output logic        wake_irq
);
  pad_fields_t fields;
  logic        resample_clr;
  logic        wake_hit;

  pad_ctl_fields u_fields (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .fields       (fields),
    .resample_clr (resample_clr)
  );

  pad_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .mode   (fields.wake),
    .clr    (resample_clr),
    .hit    (wake_hit),
    .flag   (wake_flag),
    .irq    (wake_irq)
  );

  assign rd_data   = pack_readback(fields);
  assign mux_sel   = fields.mux;
  assign io_cfg    = fields.ioc;
  assign lp_cfg    = fields.lpm;
  assign pull_sel  = fields.pull;
  assign drive_sel = fields.drv;
endmodule

// File: rtl/pad_ctl_reg_chk.sv
module pad_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [2:0]  mux_sel,
  input logic [1:0]  io_cfg,
  input logic [1:0]  lp_cfg,
  input logic [1:0]  pull_sel,
  input logic [2:0]  drive_sel,
  input logic        wake_flag,
  input logic        wake_irq,
  input logic        wake_hit,
  input logic        resample_clr
);
  localparam logic [31:0] ZERO_MASK = 32'hC047_FF98;

  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[31]) |=> $stable(mux_sel) && $stable(io_cfg) && $stable(lp_cfg));

  // R3
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[30]) |=> $stable(pull_sel) && $stable(drive_sel));

  // R4
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[22]) |=> $stable(rd_data[21:19]));

  // R5
  resample_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[22] && wr_data[21:19] == 3'b001) |=> $stable(rd_data[21:19]));

  // R5
  resample_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resample_clr && !wake_hit) |=> !wake_flag);

  // R6
  readback_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ZERO_MASK) == 32'h0);

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[21:19] == 3'b000 && !wake_flag) |=> !wake_flag);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !resample_clr) |=> wake_flag);

  // R11
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> wake_irq);

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_flag ##1 !wake_irq);

  // R12
  mux_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29:27] == mux_sel && rd_data[6:5] == pull_sel && rd_data[2:0] == drive_sel);
endmodule

bind pad_ctl_reg pad_ctl_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .mux_sel      (mux_sel),
  .io_cfg       (io_cfg),
  .lp_cfg       (lp_cfg),
  .pull_sel     (pull_sel),
  .drive_sel    (drive_sel),
  .wake_flag    (wake_flag),
  .wake_irq     (wake_irq),
  .wake_hit     (wake_hit),
  .resample_clr (resample_clr)
);

// File: tb/pad_ctl_reg_tb.sv
module pad_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pad_in = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  mux_sel, drive_sel;
  logic [1:0]  io_cfg, lp_cfg, pull_sel;
  logic        wake_flag, wake_irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model of stored fields
  int m_mux = 0, m_ioc = 0, m_lpm = 0, m_wake = 0, m_pull = 0, m_drv = 0;

  always #4 clk = ~clk;

  pad_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_in(pad_in), .mux_sel(mux_sel), .io_cfg(io_cfg), .lp_cfg(lp_cfg),
    .pull_sel(pull_sel), .drive_sel(drive_sel), .wake_flag(wake_flag), .wake_irq(wake_irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd();
    return 32'(m_mux * (1 << 27) + m_ioc * (1 << 25) + m_lpm * (1 << 23)
             + m_wake * (1 << 19) + m_pull * 32 + m_drv);
  endfunction

  task automatic model_write(input logic [31:0] d);
    int c;
    if (d[31]) begin
      m_mux = int'((d >> 27) % 8); m_ioc = int'((d >> 25) % 4); m_lpm = int'((d >> 23) % 4);
    end
    if (d[30]) begin
      m_pull = int'((d >> 5) % 4); m_drv = int'(d % 8);
    end
    if (d[22]) begin
      c = int'((d >> 19) % 8);
      if (c == 0 || c >= 4) m_wake = c;
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    model_write(d);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bring flag to 0 with mode off and pad low
  task automatic quiesce();
    pad_in = 1'b0;
    do_write(32'h0040_0000);
    wait_cyc(4);
    do_write(32'h0040_0000 | (32'd1 << 19));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] d;
    bit exp_a, exp_b, exp_c;
    seed = 32'h1234_5678;

    wait_cyc(3);
    // R1: reset state
    check(rd_data == 0 && wake_flag == 0 && wake_irq == 0 && mux_sel == 0 && pull_sel == 0
          && drive_sel == 0, "R1 reset", {rd_data, wake_flag, wake_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(2);
    check(rd_data == 0, "R1 after release", rd_data, 0);

    // R2 R3 R4 R6 R12: every qualifier combination with varied data
    for (int q = 0; q < 8; q++) begin
      for (int k = 0; k < 16; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        d = seed ^ {seed[15:0], seed[31:16]};
        d[31] = q[2]; d[30] = q[1]; d[22] = q[0];
        do_write(d);
        check(rd_data == model_rd(), "R2 R3 R4 R6 readback", rd_data, model_rd());
        check(mux_sel == 3'(m_mux) && io_cfg == 2'(m_ioc) && lp_cfg == 2'(m_lpm)
              && pull_sel == 2'(m_pull) && drive_sel == 3'(m_drv), "R12 decoded outputs",
              {mux_sel, io_cfg, lp_cfg, pull_sel, drive_sel},
              {3'(m_mux), 2'(m_ioc), 2'(m_lpm), 2'(m_pull), 3'(m_drv)});
      end
    end
    // R6: all-ones write leaves qualifier and reserved bits at zero
    do_write(32'hFFFF_FFFF);
    check(rd_data == 32'h3FB8_0067, "R6 all-ones readback", rd_data, 32'h3FB8_0067);

    // R5 R7 R8 R9: sweep every wakeup code over a low-high-low pad pattern
    for (int c = 0; c < 8; c++) begin
      quiesce();
      check(wake_flag == 0, "R5 clear before sweep", wake_flag, 0);
      do_write(32'h0040_0000 | (32'(c) << 19));
      check(rd_data[21:19] == 3'(m_wake), "R5 stored mode", rd_data[21:19], m_wake);
      wait_cyc(5);
      exp_a = (m_wake == 4);
      check(wake_flag == exp_a, "R7 R9 pad low phase", wake_flag, exp_a);
      pad_in = 1'b1; wait_cyc(5);
      exp_b = exp_a || m_wake == 6 || m_wake == 7;
      check(wake_flag == exp_b, "R7 R8 R10 pad high phase", wake_flag, exp_b);
      pad_in = 1'b0; wait_cyc(5);
      exp_c = exp_b || m_wake == 5;
      check(wake_flag == exp_c, "R8 R10 pad low again", wake_flag, exp_c);
    end

    // R7 R8 R11: exact latency of a rise detection and the irq pulse
    quiesce();
    do_write(32'h0040_0000 | (32'd6 << 19));
    @(negedge clk); pad_in = 1'b1;
    @(negedge clk);
    check(wake_flag == 0, "R8 after edge 1", wake_flag, 0);
    @(negedge clk);
    check(wake_flag == 0 && wake_irq == 0, "R8 after edge 2", {wake_flag, wake_irq}, 0);
    @(negedge clk);
    check(wake_flag == 1 && wake_irq == 1, "R11 after edge 3", {wake_flag, wake_irq}, 3);
    @(negedge clk);
    check(wake_flag == 1 && wake_irq == 0, "R11 pulse ends", {wake_flag, wake_irq}, 2);

    // R5: resample write clears the flag, mode stays rise
    do_write(32'h0040_0000 | (32'd1 << 19));
    check(wake_flag == 0, "R5 resample clears", wake_flag, 0);
    check(rd_data[21:19] == 3'b110, "R5 mode kept", rd_data[21:19], 6);
    wait_cyc(4);
    check(wake_flag == 0, "R8 steady high no retrigger", wake_flag, 0);

    // R10: detection wins over a simultaneous resample write
    pad_in = 1'b0;
    do_write(32'h0040_0000 | (32'd4 << 19));
    wait_cyc(5);
    check(wake_flag == 1, "R7 low level set", wake_flag, 1);
    do_write(32'h0040_0000 | (32'd1 << 19));
    check(wake_flag == 1, "R10 set wins over clear", wake_flag, 1);

    // R4: wake qualifier alone leaves other fields
    d = model_rd();
    do_write(32'h0040_0000 | (32'd7 << 19) | 32'h3F80_0067);
    check(rd_data == ((d & ~32'h0038_0000) | (32'd7 << 19)), "R4 isolation",
          rd_data, (d & ~32'h0038_0000) | (32'd7 << 19));

    // R1: reset mid-run returns everything to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(rd_data == 0 && wake_flag == 0, "R1 reassert", {rd_data, wake_flag}, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule